// File: doc/BRIEF.md
# Receive Frame Queue with Bad-CRC Handling Policy

This block is a packet queue on the receive side of an Ethernet MAC. Each cycle the MAC may hand it one data word, marked as a frame start, a frame end, or neither. On the end word the MAC also reports whether the frame's check sequence was wrong. The queue stores the words and releases them in order on an egress stream that a downstream consumer drains with a ready signal. Each frame out carries start and end marks. The end word also carries a "bad" flag and an error strobe.

Three static configuration bits decide what happens to a frame that ends with a CRC error. The frame can go through as if it were good. It can be flagged bad and forwarded, with or without the error strobe. Or it can be erased from the queue so the consumer never sees it. Short frames are held back until their last word arrives, so erasing one means moving the write pointer back. A frame that grows past a programmable transfer threshold is released while it is still arriving. From then on it can only be flagged, not erased. If the queue fills during a frame, that frame is cut short. Two statistic counters are kept: one for CRC-errored frames and one for overflow truncations.

Top module: `rx_pkt_fifo`

## Requirements
- R1: After reset, out_valid is 0 and both fcs_err_cnt and ovf_cnt are 0.
- R2: A frame of at most xfer_thresh words produces no egress word until its end word has been accepted. After that, all its words leave in order. out_sof is 1 on the first word only and out_eof is 1 on the last word only. A good frame ends with out_bad=0 and out_err=0.
- R3: With cfg_pass=1, a CRC-errored frame is forwarded with out_bad=0 and out_err=0, whatever cfg_drop and cfg_err_en are.
- R4: With cfg_pass=0, cfg_drop=0 and cfg_err_en=1, a CRC-errored frame is forwarded with out_bad=1 and out_err=1 on its end word.
- R5: With cfg_pass=0, cfg_drop=0 and cfg_err_en=0, a CRC-errored frame is forwarded with out_bad=1 and out_err=0.
- R6: With cfg_pass=0 and cfg_drop=1, a CRC-errored frame of at most xfer_thresh words never reaches the egress, for either value of cfg_err_en. Frames that follow it are delivered normally.
- R7: Once a frame's accepted word count exceeds xfer_thresh, out_valid rises at the next edge, before the frame ends. Such a frame is always delivered in full. If its CRC is bad and cfg_pass=0, its end word carries out_bad=1 and out_err=cfg_err_en, even with cfg_drop=1.
- R8: In drop mode, an errored frame of exactly xfer_thresh words is erased, while one of xfer_thresh+1 words is forwarded.
- R9: out_bad and out_err are 1 only on a word that has out_eof=1.
- R10: fcs_err_cnt rises by exactly one for every accepted end word that has in_crc_bad=1, in every mode, including erased frames. It stops at all ones.
- R11: If a non-end word arrives when only one slot is free, the frame is truncated, ovf_cnt rises by one, and the rest of the frame is ignored up to its end word. A truncated frame still within xfer_thresh words is erased. A longer one has that word stored as its end word, with out_bad=1 and out_err=cfg_err_en. A frame that starts while the queue is completely full is dropped and also counted.
- R12: stat_clr=1 clears both counters at the next edge, and it takes priority over a simultaneous increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pass | input | 1 | 1: treat CRC-errored frames as good |
| cfg_drop | input | 1 | 1: erase CRC-errored frames that are still held |
| cfg_err_en | input | 1 | 1: raise out_err on flagged frames |
| xfer_thresh | input | $clog2(DEPTH)+1 | Word count above which a frame is released early |
| stat_clr | input | 1 | Synchronous clear of both counters |
| in_valid | input | 1 | Ingress word present |
| in_data | input | DATA_W | Ingress word |
| in_sof | input | 1 | First word of a frame |
| in_eof | input | 1 | Last word of a frame |
| in_crc_bad | input | 1 | With in_eof: the frame's CRC is wrong |
| out_ready | input | 1 | Consumer accepts the egress word |
| out_valid | output | 1 | Egress word present |
| out_data | output | DATA_W | Egress word |
| out_sof | output | 1 | First egress word of a frame |
| out_eof | output | 1 | Last egress word of a frame |
| out_bad | output | 1 | Frame is flagged bad (end word only) |
| out_err | output | 1 | Error strobe (end word only) |
| fcs_err_cnt | output | CNT_W | CRC-errored frame count |
| ovf_cnt | output | CNT_W | Truncated or dropped-on-full frame count |

## Verification
The handling policy is tested with errored frames under each of the four configuration cases. A good frame in the same run shows that errored frames are the only ones affected. Frames of exactly the threshold length and one word longer separate erasure from forced forwarding. A long errored frame in drop mode shows that early release overrides the drop setting. With the consumer stalled, frames are made to overrun the queue from three positions: under the threshold, above it, and at a frame start. These runs tell erasure apart from truncated forwarding, and show the drop of a frame that finds no room at all.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic [1:0] {
      WS_IDLE,
      WS_FRAME,
      WS_SKIP
   } wr_state_e;

   typedef struct packed {
      logic sof;
      logic eof;
      logic bad;
      logic err;
   } tag_t;

   // Decide the fate of a finished frame: {keep, bad, err}
   function automatic logic [2:0] end_policy(input logic crc_bad,
                                             input logic pass,
                                             input logic drop,
                                             input logic err_en,
                                             input logic released);
      if (!crc_bad || pass) return 3'b100;
      if (drop && !released) return 3'b010;
      return {1'b1, 1'b1, err_en};
   endfunction

endpackage

// File: rtl/rxf_mem.sv
module rxf_mem #(
   parameter int WIDTH = 12,
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] arr [DEPTH];

   always_ff @(posedge clk) begin
      if (we) arr[waddr] <= wdata;
   end

   assign rdata = arr[raddr];

endmodule

// File: rtl/rxf_sat_cnt.sv
module rxf_sat_cnt #(
   parameter int W        = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   logic [W-1:0] nxt;

   generate
      if (SATURATE) begin : g_sat
         always_comb nxt = (&cnt) ? cnt : cnt + 1'b1;
      end else begin : g_wrap
         always_comb nxt = cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= nxt;
   end

   a_r12_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

   a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/rxf_wr_ctl.sv
module rxf_wr_ctl
   import rxf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1,
   localparam int LW    = AW + 2,
   localparam int THR_W = AW + 1,
   localparam int EW    = DATA_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic              in_crc_bad,
   input  logic              cfg_pass,
   input  logic              cfg_drop,
   input  logic              cfg_err_en,
   input  logic [THR_W-1:0]  xfer_thresh,
   input  logic [PW-1:0]     rd_ptr,
   output logic              mem_we,
   output logic [AW-1:0]     mem_waddr,
   output logic [EW-1:0]     mem_wdata,
   output logic [PW-1:0]     cmt_ptr,
   output logic              ovf_pulse,
   output logic              fcs_pulse
);

   initial begin : p_param_check
      assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("rxf_wr_ctl: DEPTH must be a power of two of at least 4");
      assert (DATA_W >= 1) else $error("rxf_wr_ctl: DATA_W must be positive");
   end

   wr_state_e     st, st_nx;
   logic [PW-1:0] wr_ptr, wr_nx, sof_ptr, sof_nx, cmt_nx, base_ptr;
   logic [PW-1:0] used, free_slots;
   logic [LW-1:0] len, len_nx, len_new;
   logic          start, cont, acc, released;
   logic [2:0]    pol;
   tag_t          tag;

   assign used       = wr_ptr - rd_ptr;
   assign free_slots = PW'(DEPTH) - used;
   assign start      = in_valid && (st == WS_IDLE) && in_sof;
   assign cont       = in_valid && (st == WS_FRAME);
   assign acc        = start || cont;
   assign base_ptr   = start ? wr_ptr : sof_ptr;
   assign len_new    = start ? LW'(1) : ((&len) ? len : len + 1'b1);
   assign released   = len_new > LW'(xfer_thresh);
   assign pol        = end_policy(in_crc_bad, cfg_pass, cfg_drop, cfg_err_en, released);
   assign fcs_pulse  = in_valid && in_eof && in_crc_bad;

   always_comb begin
      st_nx     = st;
      wr_nx     = wr_ptr;
      sof_nx    = sof_ptr;
      cmt_nx    = cmt_ptr;
      len_nx    = len;
      mem_we    = 1'b0;
      ovf_pulse = 1'b0;
      tag       = '0;
      if (st == WS_SKIP) begin
         if (in_valid && in_eof) st_nx = WS_IDLE;
      end else if (acc) begin
         len_nx  = len_new;
         tag.sof = start;
         if (start) sof_nx = wr_ptr;
         if (free_slots == '0) begin
            // no room at all: frame is dropped whole
            ovf_pulse = 1'b1;
            wr_nx     = base_ptr;
            st_nx     = in_eof ? WS_IDLE : WS_SKIP;
         end else if (free_slots == PW'(1) && !in_eof) begin
            // last slot: truncate the frame here
            ovf_pulse = 1'b1;
            st_nx     = WS_SKIP;
            if (released) begin
               mem_we  = 1'b1;
               tag.eof = 1'b1;
               tag.bad = 1'b1;
               tag.err = cfg_err_en;
               wr_nx   = wr_ptr + 1'b1;
               cmt_nx  = wr_ptr + 1'b1;
            end else begin
               wr_nx = base_ptr;
            end
         end else if (in_eof) begin
            st_nx = WS_IDLE;
            if (pol[2]) begin
               mem_we  = 1'b1;
               tag.eof = 1'b1;
               tag.bad = pol[1];
               tag.err = pol[0];
               wr_nx   = wr_ptr + 1'b1;
               cmt_nx  = wr_ptr + 1'b1;
            end else begin
               wr_nx = base_ptr;
            end
         end else begin
            st_nx  = WS_FRAME;
            mem_we = 1'b1;
            wr_nx  = wr_ptr + 1'b1;
            if (released) cmt_nx = wr_ptr + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= WS_IDLE;
         wr_ptr  <= '0;
         sof_ptr <= '0;
         cmt_ptr <= '0;
         len     <= '0;
      end else begin
         st      <= st_nx;
         wr_ptr  <= wr_nx;
         sof_ptr <= sof_nx;
         cmt_ptr <= cmt_nx;
         len     <= len_nx;
      end
   end

   assign mem_waddr = wr_ptr[AW-1:0];
   assign mem_wdata = {tag, in_data};

   a_r11_never_overfill: assert property (@(posedge clk) disable iff (!rst_n)
      used <= PW'(DEPTH));

   a_r11_full_only_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WS_FRAME && in_valid) |-> (free_slots != '0));

   a_r7_commit_not_past_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_ptr - rd_ptr) <= used);

   a_r6_rewind_to_sof: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (wr_ptr == $past(wr_ptr) || wr_ptr == $past(wr_ptr) + 1'b1
                || wr_ptr == $past(sof_ptr)));

endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
   import rxf_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int DEPTH   = 16,
   parameter int CNT_W   = 32,
   parameter bit CNT_SAT = 1'b1,
   localparam int AW     = $clog2(DEPTH),
   localparam int PW     = AW + 1,
   localparam int THR_W  = AW + 1,
   localparam int EW     = DATA_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_pass,
   input  logic              cfg_drop,
   input  logic              cfg_err_en,
   input  logic [THR_W-1:0]  xfer_thresh,
   input  logic              stat_clr,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic              in_crc_bad,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sof,
   output logic              out_eof,
   output logic              out_bad,
   output logic              out_err,
   output logic [CNT_W-1:0]  fcs_err_cnt,
   output logic [CNT_W-1:0]  ovf_cnt
);

   initial begin : p_param_check
      assert (CNT_W >= 2 && CNT_W <= 64) else $error("rx_pkt_fifo: CNT_W out of range");
      assert (DEPTH <= 4096) else $error("rx_pkt_fifo: DEPTH too large");
   end

   logic              mem_we, ovf_pulse, fcs_pulse;
   logic [AW-1:0]     mem_waddr;
   logic [EW-1:0]     mem_wdata, mem_rdata;
   logic [PW-1:0]     rd_ptr, cmt_ptr;
   tag_t              rtag;
   logic [DATA_W-1:0] rdat;

   rxf_wr_ctl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .in_sof     (in_sof),
      .in_eof     (in_eof),
      .in_crc_bad (in_crc_bad),
      .cfg_pass   (cfg_pass),
      .cfg_drop   (cfg_drop),
      .cfg_err_en (cfg_err_en),
      .xfer_thresh(xfer_thresh),
      .rd_ptr     (rd_ptr),
      .mem_we     (mem_we),
      .mem_waddr  (mem_waddr),
      .mem_wdata  (mem_wdata),
      .cmt_ptr    (cmt_ptr),
      .ovf_pulse  (ovf_pulse),
      .fcs_pulse  (fcs_pulse)
   );

   rxf_mem #(.WIDTH(EW), .DEPTH(DEPTH)) u_mem (
      .clk  (clk),
      .we   (mem_we),
      .waddr(mem_waddr),
      .wdata(mem_wdata),
      .raddr(rd_ptr[AW-1:0]),
      .rdata(mem_rdata)
   );

   rxf_sat_cnt #(.W(CNT_W), .SATURATE(CNT_SAT)) u_fcs_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (stat_clr),
      .inc  (fcs_pulse),
      .cnt  (fcs_err_cnt)
   );

   rxf_sat_cnt #(.W(CNT_W), .SATURATE(CNT_SAT)) u_ovf_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (stat_clr),
      .inc  (ovf_pulse),
      .cnt  (ovf_cnt)
   );

   // read side: only committed words are visible
   assign out_valid = (rd_ptr != cmt_ptr);

   always_ff @(posedge clk) begin
      if (!rst_n)                       rd_ptr <= '0;
      else if (out_valid && out_ready)  rd_ptr <= rd_ptr + 1'b1;
   end

   assign {rtag, rdat} = mem_rdata;
   assign out_data = out_valid ? rdat     : '0;
   assign out_sof  = out_valid && rtag.sof;
   assign out_eof  = out_valid && rtag.eof;
   assign out_bad  = out_valid && rtag.bad;
   assign out_err  = out_valid && rtag.err;

   a_r9_flags_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      (out_bad || out_err) |-> out_eof);

   a_r2_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eof)));

endmodule

// File: tb/sim_rx_pkt_fifo.sv
`timescale 1ns/1ps
module sim_rx_pkt_fifo;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cfg_pass, cfg_drop, cfg_err_en;
   logic [4:0] xfer_thresh;
   logic       stat_clr;
   logic       in_valid, in_sof, in_eof, in_crc_bad;
   logic [7:0] in_data;
   logic       out_ready;
   logic       out_valid, out_sof, out_eof, out_bad, out_err;
   logic [7:0] out_data;
   logic [31:0] fcs_err_cnt, ovf_cnt;

   always #2 clk = ~clk;

   rx_pkt_fifo u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_pass(cfg_pass), .cfg_drop(cfg_drop), .cfg_err_en(cfg_err_en),
      .xfer_thresh(xfer_thresh), .stat_clr(stat_clr),
      .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
      .in_eof(in_eof), .in_crc_bad(in_crc_bad),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
      .out_sof(out_sof), .out_eof(out_eof), .out_bad(out_bad), .out_err(out_err),
      .fcs_err_cnt(fcs_err_cnt), .ovf_cnt(ovf_cnt)
   );

   int n_chk = 0, n_bad = 0;
   int exp_fcs = 0, exp_ovf = 0;
   bit done = 1'b0;
   logic [7:0] cap_d[$];
   bit cap_s[$], cap_e[$], cap_b[$], cap_r[$];

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic set_cfg(input bit p, input bit d, input bit e, input int thr);
      @(negedge clk);
      cfg_pass = p; cfg_drop = d; cfg_err_en = e; xfer_thresh = 5'(thr);
   endtask

   task automatic send_frame(input int id, input int len, input bit bad, input int probe,
                             output bit probe_v, output bit post_v);
      probe_v = 1'b0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (i == probe) probe_v = out_valid;
         in_valid   = 1'b1;
         in_data    = 8'(id * 32 + i);
         in_sof     = (i == 0);
         in_eof     = (i == len - 1);
         in_crc_bad = bad && (i == len - 1);
      end
      @(negedge clk);
      post_v = out_valid;
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_crc_bad = 1'b0;
      if (bad) exp_fcs++;
   endtask

   task automatic drain();
      int idle = 0;
      cap_d.delete(); cap_s.delete(); cap_e.delete(); cap_b.delete(); cap_r.delete();
      @(negedge clk);
      out_ready = 1'b1;
      while (idle < 4) begin
         if (out_valid) begin
            cap_d.push_back(out_data); cap_s.push_back(out_sof); cap_e.push_back(out_eof);
            cap_b.push_back(out_bad);  cap_r.push_back(out_err);
            idle = 0;
         end else idle++;
         @(negedge clk);
      end
      out_ready = 1'b0;
   endtask

   task automatic check_frame(input string req, input int id, input int len, input bit eb, input bit ee);
      chk(req, "egress word count", cap_d.size(), len);
      if (cap_d.size() == len && len > 0) begin
         int mis = 0;
         for (int i = 0; i < len; i++) begin
            bit last = (i == len - 1);
            if (cap_d[i] != 8'(id * 32 + i)) mis++;
            if (cap_s[i] != (i == 0)) mis++;
            if (cap_e[i] != last) mis++;
            if (!last && (cap_b[i] || cap_r[i])) mis++;
         end
         chk(req, "data/flag mismatches (R9 flags only on last)", mis, 0);
         chk(req, "bad flag on end word", cap_b[len-1], eb);
         chk(req, "error strobe on end word", cap_r[len-1], ee);
      end
   endtask

   task automatic t_reset();
      chk("R1", "out_valid after reset", out_valid, 0);
      chk("R1", "fcs_err_cnt after reset", fcs_err_cnt, 0);
      chk("R1", "ovf_cnt after reset", ovf_cnt, 0);
   endtask

   task automatic t_good();
      bit pv, qv;
      set_cfg(0, 0, 0, 8);
      send_frame(1, 4, 0, 3, pv, qv);
      chk("R2", "held before end word", pv, 0);
      chk("R2", "visible after end word", qv, 1);
      drain();
      check_frame("R2", 1, 4, 0, 0);
   endtask

   task automatic t_pass();
      bit pv, qv;
      set_cfg(1, 1, 1, 8);
      send_frame(2, 5, 1, -1, pv, qv);
      drain();
      check_frame("R3", 2, 5, 0, 0);
      chk("R10", "fcs count after pass frame", fcs_err_cnt, exp_fcs);
   endtask

   task automatic t_mark(input bit strobe);
      bit pv, qv;
      set_cfg(0, 0, strobe, 8);
      send_frame(3, 6, 1, -1, pv, qv);
      drain();
      if (strobe) check_frame("R4", 3, 6, 1, 1);
      else        check_frame("R5", 3, 6, 1, 0);
   endtask

   task automatic t_drop();
      bit pv, qv;
      set_cfg(0, 1, 1, 8);
      send_frame(4, 6, 1, -1, pv, qv);
      send_frame(5, 3, 0, -1, pv, qv);
      drain();
      check_frame("R6", 5, 3, 0, 0);
      set_cfg(0, 1, 0, 8);
      send_frame(6, 2, 1, -1, pv, qv);
      drain();
      chk("R6", "erased frame with strobe off", cap_d.size(), 0);
      chk("R10", "fcs count includes erased frames", fcs_err_cnt, exp_fcs);
   endtask

   task automatic t_cut();
      bit pv, qv;
      set_cfg(0, 1, 1, 8);
      send_frame(7, 12, 1, 9, pv, qv);
      chk("R7", "released after word thresh+1", pv, 1);
      drain();
      check_frame("R7", 7, 12, 1, 1);
   endtask

   task automatic t_boundary();
      bit pv, qv;
      set_cfg(0, 1, 0, 8);
      send_frame(1, 8, 1, -1, pv, qv);
      send_frame(2, 9, 1, -1, pv, qv);
      drain();
      check_frame("R8", 2, 9, 1, 0);
   endtask

   task automatic t_ovf_held();
      bit pv, qv;
      set_cfg(0, 0, 1, 20);
      send_frame(3, 18, 0, -1, pv, qv);
      exp_ovf++;
      chk("R11", "ovf count after held truncation", ovf_cnt, exp_ovf);
      send_frame(4, 3, 0, -1, pv, qv);
      drain();
      check_frame("R11", 4, 3, 0, 0);
   endtask

   task automatic t_ovf_released();
      bit pv, qv;
      set_cfg(0, 0, 1, 4);
      send_frame(5, 20, 0, -1, pv, qv);
      exp_ovf++;
      chk("R11", "ovf count after released truncation", ovf_cnt, exp_ovf);
      drain();
      check_frame("R11", 5, 16, 1, 1);
   endtask

   task automatic t_full_start();
      bit pv, qv;
      set_cfg(0, 0, 0, 20);
      send_frame(6, 16, 0, -1, pv, qv);
      send_frame(7, 2, 0, -1, pv, qv);
      exp_ovf++;
      chk("R11", "ovf count after start on full queue", ovf_cnt, exp_ovf);
      drain();
      check_frame("R11", 6, 16, 0, 0);
   endtask

   task automatic t_clear();
      set_cfg(0, 1, 0, 8);
      chk("R10", "fcs count before clear", fcs_err_cnt, exp_fcs);
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_crc_bad = 1'b1;
      in_data = 8'hA5; stat_clr = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_crc_bad = 1'b0; stat_clr = 1'b0;
      chk("R12", "fcs count cleared over increment", fcs_err_cnt, 0);
      chk("R12", "ovf count cleared", ovf_cnt, 0);
      chk("R6", "single-word errored frame erased", out_valid, 0);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      rst_n = 1'b0; cfg_pass = 0; cfg_drop = 0; cfg_err_en = 0; xfer_thresh = 5'd8;
      stat_clr = 0; in_valid = 0; in_sof = 0; in_eof = 0; in_crc_bad = 0; in_data = '0;
      out_ready = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_good();
      t_pass();
      t_mark(1'b1);
      t_mark(1'b0);
      t_drop();
      t_cut();
      t_boundary();
      t_ovf_held();
      t_ovf_released();
      t_full_start();
      t_clear();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

endmodule